// File: doc/BRIEF.md
# Clock Control Register Bank

This block is the software-visible register file of a clock controller. It sits on a simple word-addressed read/write bus and decodes a 4 KB byte window. The window holds one mode register, two post-divider registers, two PLL control registers, three clock-gate registers, one read-only power-management register and one constant word. Each register has its own reset value and its own write mask. Unmapped words read as zero and ignore writes.

The block only stores settings. It does not generate, divide or gate any clock. Logic downstream recomputes the derived frequencies from these registers. To tell that logic when to do so, the bank raises a single-cycle recompute pulse after every write that can change a frequency, and once after reset is released.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset the registers hold these values. Mode (word 0) is 0x074B0B7B. Post-divider A (word 1) is 0xFF870B48. Post-divider B (word 2) is 0x49FCFE7F. Main PLL (word 4) is 0x04001800. Secondary PLL (word 6) is 0x04043001. Gates 0/1/2 (words 8/9/10) are 0xFFFFFFFF. Power management (word 23) is 0x80209828. While reset is held, rdata is 0 and recalc_pulse is 0.
- R2: A write to word 0 stores the data ANDed with 0x3B6FDFFF, with bit 26 then set to one.
- R3: A write to word 1 stores the data ANDed with 0xFF9F3FFF.
- R4: A write to word 4 or word 6 stores the data ANDed with 0xBFFF3FFF.
- R5: A write to word 2, 8, 9 or 10 stores all 32 data bits.
- R6: A read of word 18 returns 0x00004040. A read of word 23 returns the power-management value. Writes to word 18 or word 23 change nothing that reads back.
- R7: A read of any other word returns 0. A write to any other word changes no register.
- R8: A write to word 0, 1, 2, 4 or 6 makes recalc_pulse high in the cycle after the write edge.
- R9: Writes to the gate words, to words 18 and 23 and to unmapped words do not raise recalc_pulse. With no qualifying write, recalc_pulse stays low.
- R10: recalc_pulse is high for exactly one cycle after the first clock edge that follows reset release.
- R11: rdata is updated at the clock edge where rd_en is high and holds its value while rd_en is low. A read and a write to the same word in the same cycle return the value from before the write.
- R12: The word index is addr[ADDR_W-1:2]. The two lowest address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (12) | Byte address within the window |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| recalc_pulse | output | 1 | One-cycle recompute request |

## Verification
The assertions assume that the bus drives at most one access per cycle on a stable address, and that rd_en and wr_en are never unknown after reset. The checks on write masks and single-hot write decode depend on that. The stimulus changes inputs only on the falling clock edge. It keeps every strobe at a defined 0 or 1. It picks words from the mapped, constant, read-only and unmapped sets, including the highest word in the window. A behavioural model of the register contents predicts rdata and recalc_pulse on every cycle, including cycles where reads and writes to the same word coincide.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int unsigned NUM_REGS   = 9;
   localparam int unsigned CONST_WORD = 18;
   localparam logic [31:0] CONST_VAL  = 32'h0000_4040;

   // index -> bus word
   function automatic int unsigned reg_word(int unsigned i);
      case (i)
         0: return 0;   1: return 1;   2: return 2;
         3: return 4;   4: return 6;   5: return 8;
         6: return 9;   7: return 10;  default: return 23;
      endcase
   endfunction

   function automatic logic [31:0] reg_rst(int unsigned i);
      case (i)
         0: return 32'h074B_0B7B;
         1: return 32'hFF87_0B48;
         2: return 32'h49FC_FE7F;
         3: return {2'b00, 4'd1, 10'd0, 2'b00, 4'd6, 10'd0};
         4: return {2'b00, 4'd1, 10'd4, 2'b00, 4'hC, 10'd1};
         5, 6, 7: return 32'hFFFF_FFFF;
         default: return 32'h8020_9828;
      endcase
   endfunction

   function automatic logic [31:0] reg_mask(int unsigned i);
      case (i)
         0: return 32'h3B6F_DFFF;
         1: return 32'hFF9F_3FFF;
         3, 4: return 32'hBFFF_3FFF;
         8: return 32'h0000_0000;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [31:0] reg_set(int unsigned i);
      return (i == 0) ? 32'h0400_0000 : 32'h0000_0000;
   endfunction

   function automatic bit reg_writable(int unsigned i);
      return i != 8;
   endfunction

   function automatic bit reg_freq(int unsigned i);
      return i <= 4;
   endfunction
endpackage

// File: rtl/clkctl_reg.sv
module clkctl_reg #(
   parameter int unsigned DATA_W   = 32,
   parameter logic [31:0] RST_VAL  = '0,
   parameter logic [31:0] WMASK    = '1,
   parameter logic [31:0] WSET     = '0,
   parameter bit          WRITABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam logic [DATA_W-1:0] KEEP = DATA_W'(WMASK | WSET);

   generate
      if (WRITABLE) begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= DATA_W'(RST_VAL);
            else if (we) q <= (wdata & DATA_W'(WMASK)) | DATA_W'(WSET);
         end

         a_r3_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> ((q & ~KEEP) == '0));
         a_r2_forced_bits: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> ((q & DATA_W'(WSET)) == DATA_W'(WSET)));
      end else begin : g_ro
         logic unused_ro;
         assign unused_ro = ^{we, wdata, clk, rst_n};
         assign q = DATA_W'(RST_VAL);
      end
   endgenerate
endmodule

// File: rtl/clkctl_wdec.sv
module clkctl_wdec
   import clkctl_pkg::*;
#(
   parameter int unsigned WORD_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [WORD_W-1:0]   word,
   output logic [NUM_REGS-1:0] we,
   output logic                freq_hit
);
   logic [NUM_REGS-1:0] freq_sel;

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
         assign we[i]       = wr_en && reg_writable(i) && (word == WORD_W'(reg_word(i)));
         assign freq_sel[i] = reg_freq(i);
      end
   endgenerate

   assign freq_hit = |(we & freq_sel);

   a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we));
   a_r9_no_write_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (we == '0 && !freq_hit));
endmodule

// File: rtl/clkctl_rdsel.sv
module clkctl_rdsel
   import clkctl_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORD_W = 10
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             rd_en,
   input  logic [WORD_W-1:0]                word,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
   output logic [DATA_W-1:0]                rdata
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int unsigned i = 0; i < NUM_REGS; i++)
         if (word == WORD_W'(reg_word(i))) sel = regs[i];
      if (word == WORD_W'(CONST_WORD)) sel = DATA_W'(CONST_VAL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= sel;
   end

   a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
   import clkctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              recalc_pulse
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   generate
      if (ADDR_W < 7) begin : g_chk_addr
         $error("ADDR_W must reach word 23");
      end
      if (DATA_W != 32) begin : g_chk_data
         $error("register layout needs DATA_W of 32");
      end
   endgenerate

   logic [WORD_W-1:0]               word;
   logic [1:0]                      unused_lsb;
   logic [NUM_REGS-1:0]             we;
   logic                            freq_hit;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic                            boot_q;

   assign word       = addr[ADDR_W-1:2];
   assign unused_lsb = addr[1:0];

   clkctl_wdec #(.WORD_W(WORD_W)) u_wdec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word(word),
      .we(we), .freq_hit(freq_hit)
   );

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         clkctl_reg #(
            .DATA_W  (DATA_W),
            .RST_VAL (reg_rst(i)),
            .WMASK   (reg_mask(i)),
            .WSET    (reg_set(i)),
            .WRITABLE(reg_writable(i))
         ) u_reg (
            .clk(clk), .rst_n(rst_n), .we(we[i]), .wdata(wdata), .q(regs[i])
         );
      end
   endgenerate

   clkctl_rdsel #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_rdsel (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .word(word),
      .regs(regs), .rdata(rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q       <= 1'b0;
         recalc_pulse <= 1'b0;
      end else begin
         boot_q       <= 1'b1;
         recalc_pulse <= !boot_q || (wr_en && freq_hit);
      end
   end

   a_r8_pulse_on_freq_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && freq_hit) |=> recalc_pulse);
   a_r9_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_q && !(wr_en && freq_hit)) |=> !recalc_pulse);
   a_r10_boot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_q |=> recalc_pulse);
endmodule

// File: tb/clkctl_regbank_bench.sv
`timescale 1ns/1ps
module clkctl_regbank_bench;
   localparam int ADDR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_en = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic              recalc_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] mdl [0:31];
   logic [31:0] exp_rdata = '0;
   bit          exp_recalc = 0;
   bit          boot_pending = 0;

   always #5 clk = ~clk;

   clkctl_regbank u_clkctl_regbank (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .recalc_pulse(recalc_pulse)
   );

   function automatic bit mapped(int w);
      return w inside {0, 1, 2, 4, 6, 8, 9, 10, 23};
   endfunction

   function automatic logic [31:0] mread(int w);
      if (w == 18) return 32'h0000_4040;
      if (mapped(w)) return mdl[w];
      return 32'h0;
   endfunction

   task automatic mwrite(int w, logic [31:0] d);
      case (w)
         0: mdl[0] = (d & 32'h3B6F_DFFF) | 32'h0400_0000;
         1: mdl[1] = d & 32'hFF9F_3FFF;
         2, 8, 9, 10: mdl[w] = d;
         4, 6: mdl[w] = d & 32'hBFFF_3FFF;
         default: ;
      endcase
   endtask

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // one bus cycle, started at a falling edge
   task automatic step(bit r, bit w, int word, logic [1:0] lsb, logic [31:0] d, string tag);
      rd_en = r; wr_en = w; wdata = d;
      addr  = ADDR_W'(word * 4) | ADDR_W'(lsb);
      @(posedge clk);
      if (r) exp_rdata = mread(word);
      exp_recalc   = boot_pending || (w && (word inside {0, 1, 2, 4, 6}));
      boot_pending = 0;
      if (w) mwrite(word, d);
      @(negedge clk);
      chk(tag, "rdata", rdata, exp_rdata);
      chk(tag, "recalc", {31'b0, recalc_pulse}, {31'b0, exp_recalc});
      rd_en = 0; wr_en = 0;
   endtask

   task automatic wr(int word, logic [31:0] d, string tag);
      step(0, 1, word, 2'b00, d, tag);
   endtask

   task automatic rd(int word, string tag);
      step(1, 0, word, 2'b00, 32'h0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
      mdl[0] = 32'h074B_0B7B;  mdl[1] = 32'hFF87_0B48;  mdl[2] = 32'h49FC_FE7F;
      mdl[4] = 32'h0400_1800;  mdl[6] = 32'h0404_3001;
      mdl[8] = 32'hFFFF_FFFF;  mdl[9] = 32'hFFFF_FFFF;  mdl[10] = 32'hFFFF_FFFF;
      mdl[23] = 32'h8020_9828;

      repeat (3) @(negedge clk);
      chk("R1", "rdata in reset", rdata, 32'h0);
      chk("R1", "recalc in reset", {31'b0, recalc_pulse}, 32'h0);
      rst_n = 1'b1;
      boot_pending = 1;
      step(0, 0, 0, 2'b00, 32'h0, "R10");
      step(0, 0, 0, 2'b00, 32'h0, "R10");

      foreach (mdl[i]) if (mapped(i)) rd(i, "R1");

      wr(0, 32'hFFFF_FFFF, "R8"); rd(0, "R2");
      wr(0, 32'h0000_0000, "R8"); rd(0, "R2");
      wr(1, 32'hFFFF_FFFF, "R3"); rd(1, "R3");
      wr(2, 32'hDEAD_BEEF, "R5"); rd(2, "R5");
      wr(4, 32'hFFFF_FFFF, "R4"); rd(4, "R4");
      wr(6, 32'h1234_5678, "R4"); rd(6, "R4");
      wr(8, 32'h0F0F_0F0F, "R9"); rd(8, "R5");
      wr(9, 32'h0000_0000, "R9"); rd(9, "R5");
      wr(10, 32'hA5A5_5A5A, "R9"); rd(10, "R5");

      wr(23, 32'h0000_0000, "R6"); rd(23, "R6");
      wr(18, 32'hFFFF_FFFF, "R6"); rd(18, "R6");

      foreach (mdl[i]) if (!mapped(i) && i != 18) begin
         wr(i, 32'hFFFF_FFFF, "R7"); rd(i, "R7");
      end
      wr(1023, 32'hFFFF_FFFF, "R7"); rd(1023, "R7");
      rd(0, "R7");

      step(1, 1, 2, 2'b00, 32'h1111_2222, "R11");
      step(0, 0, 0, 2'b00, 32'h0, "R11");
      rd(2, "R11");

      step(0, 1, 1, 2'b11, 32'h0000_00A5, "R12");
      step(1, 0, 1, 2'b10, 32'h0, "R12");

      for (int n = 0; n < 400; n++) begin
         int pick [14] = '{0, 1, 2, 3, 4, 6, 8, 9, 10, 17, 18, 23, 31, 1023};
         int w = pick[$urandom_range(0, 13)];
         step(1'($urandom), 1'($urandom), w, 2'($urandom), $urandom, "R8");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule